// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This peripheral guards a system against software that stops running. Software programs a starting count in coarse ticks and then has to rewrite a reload register before that count runs out. One tick nominally lasts 0.6 seconds. A prescaler derives the tick from the core clock, and its division ratio is a parameter so that simulation can use a short tick. The first time the count runs out, the block sets a warning status bit and starts counting again from the programmed value. It asks for a system reset only if the count runs out a second time with no reload in between. A no-reboot guard flag can stop that request. Software can set the flag, and a board strap can force it on.

All access goes through a 16-bit word bus with a 5-bit address. Writes are single-cycle strobes and reads are combinational. The counter is held by a halt bit in the control register, and after reset the block comes up halted. A small state machine tracks how many times the count has run out. It has two states:
- `ST_FRESH`: no expiry since the last reload. The transition *warn* (expiry in `ST_FRESH`) moves it to `ST_WARNED`.
- `ST_WARNED`: one expiry already seen. The transition *bite* (expiry in `ST_WARNED`) moves it back to `ST_FRESH`.
- In either state, the transition *rearm* (any write to the reload register) returns it to `ST_FRESH`.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the block reads as follows. Control (0x08) reads 0x0800, which is halted. The start-value register (0x12) reads 0x0032, which is 50 ticks. Count (0x00) reads 50. Guard (0x0A) reads 1. Both status registers read 0. `rst_req` is low.
- R2: While control bit 11 is 0, the count decrements once every `TICK_DIV` clocks. Reading offset 0x00 returns the count in bits 9:0, with the upper bits reading 0.
- R3: While control bit 11 is 1, the count and the tick prescaler are frozen. All 16 bits of control read back exactly as written.
- R4: A write of any data to offset 0x00 loads the count from the start-value field, restarts the prescaler and returns the stage machine to `ST_FRESH`. If the block is halted, counting begins only when bit 11 is cleared.
- R5: Offset 0x12 holds a 10-bit start-value field in bits 9:0. A write whose field is below 4 leaves the old field unchanged. Bits 15:10 always take the written data.
- R6: A tick that arrives when the count is 0 is an expiry, and it reloads the count from the start-value field. A first expiry sets status-1 bit 3 (offset 0x04) and does not request a reset.
- R7: A second expiry with no reload in between sets status-2 bit 1 (offset 0x06). If the guard is clear, it also drives `rst_req` high for exactly one clock.
- R8: The guard reads at offset 0x0A bit 0 as the stored flag OR `noreboot_strap`. When the guard reads 1, a second expiry does not drive `rst_req` and sets status-2 bit 0 instead.
- R9: Status-2 bits 0 and 1 and status-1 bit 3 are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R10: A reload written after a first expiry makes the next expiry a first expiry again: it sets status-1 bit 3 and does not set status-2 bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 5 | Byte offset of the accessed word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| noreboot_strap | input | 1 | Board strap that forces the guard flag on |
| rst_req | output | 1 | One-clock system reset request |

## Verification
- **Countdown:** the countdown runs from many random start values and is sampled after random numbers of clocks. This separates a correct tick period and decrement from off-by-one prescaler or load timing.
- **Directed expiry runs:** separate runs cover the guard clear, the guard set by the strap, and a reload placed between the two expiries. These separate the *warn*, *bite* and *rearm* transitions, and show whether the reset request is gated by the guard.
- **Register writes:** random writes to the start-value register, including illegal fields, check the ignore rule. Random halted control writes check that control reads back exactly.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_RELOAD = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT1  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT2  = 5'h06;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_GUARD  = 5'h0A;
    localparam logic [ADDR_W-1:0] OFF_START  = 5'h12;

    localparam int HALT_BIT  = 11;
    localparam int WARN_BIT  = 3;
    localparam int BLOCK_BIT = 0;
    localparam int BITE_BIT  = 1;
    localparam int MIN_START = 4;

    typedef enum logic [0:0] {
        ST_FRESH  = 1'b0,
        ST_WARNED = 1'b1
    } stage_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int TICK_DIV = 120_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] div_q;

    assign tick = run && !restart && (div_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (!run || restart || div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int CNT_W = 10,
    parameter int START_DEFAULT = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    assign expire = tick && (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= CNT_W'(START_DEFAULT);
        else if (load || expire)
            count <= start_val;
        else if (tick)
            count <= count - 1'b1;
    end

    // R6
    expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == $past(start_val)));
endmodule

// File: rtl/wdog_stage_fsm.sv
module wdog_stage_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic rearm,
    output logic warn_evt,
    output logic bite_evt
);
    stage_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FRESH:  if (expire) state_d = ST_WARNED;
            ST_WARNED: if (expire) state_d = ST_FRESH;
            default:   state_d = ST_FRESH;
        endcase
        if (rearm)
            state_d = ST_FRESH;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_FRESH;
        else
            state_q <= state_d;
    end

    always_comb begin
        warn_evt = 1'b0;
        bite_evt = 1'b0;
        unique case (state_q)
            ST_FRESH:  warn_evt = expire && !rearm;
            ST_WARNED: bite_evt = expire && !rearm;
            default: ;
        endcase
    end

    // R10
    rearm_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (state_q == ST_FRESH));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int START_DEFAULT = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              noreboot_strap,
    input  logic [CNT_W-1:0]  count,
    input  logic              warn_evt,
    input  logic              bite_evt,
    output logic              halt,
    output logic              reload_wr,
    output logic [CNT_W-1:0]  start_val,
    output logic              guard_eff
);
    localparam logic [BUS_W-1:0] CTRL_RST = BUS_W'(1) << HALT_BIT;

    logic [BUS_W-1:0]       ctrl_q;
    logic [BUS_W-1:CNT_W]   start_hi_q;
    logic [CNT_W-1:0]       start_q;
    logic                   guard_q;
    logic                   warn_q;
    logic                   block_q;
    logic                   bite_q;

    logic wr_ctrl, wr_start, wr_guard, wr_stat1, wr_stat2;

    assign reload_wr = bus_wr && (bus_addr == OFF_RELOAD);
    assign wr_ctrl   = bus_wr && (bus_addr == OFF_CTRL);
    assign wr_start  = bus_wr && (bus_addr == OFF_START);
    assign wr_guard  = bus_wr && (bus_addr == OFF_GUARD);
    assign wr_stat1  = bus_wr && (bus_addr == OFF_STAT1);
    assign wr_stat2  = bus_wr && (bus_addr == OFF_STAT2);

    assign halt      = ctrl_q[HALT_BIT];
    assign start_val = start_q;
    assign guard_eff = guard_q || noreboot_strap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= CTRL_RST;
            start_hi_q <= '0;
            start_q    <= CNT_W'(START_DEFAULT);
            guard_q    <= 1'b1;
        end else begin
            if (wr_ctrl)
                ctrl_q <= bus_wdata;
            if (wr_start) begin
                start_hi_q <= bus_wdata[BUS_W-1:CNT_W];
                if (bus_wdata[CNT_W-1:0] >= CNT_W'(MIN_START))
                    start_q <= bus_wdata[CNT_W-1:0];
            end
            if (wr_guard)
                guard_q <= bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warn_q  <= 1'b0;
            block_q <= 1'b0;
            bite_q  <= 1'b0;
        end else begin
            if (warn_evt)
                warn_q <= 1'b1;
            else if (wr_stat1 && bus_wdata[WARN_BIT])
                warn_q <= 1'b0;

            if (bite_evt && guard_eff)
                block_q <= 1'b1;
            else if (wr_stat2 && bus_wdata[BLOCK_BIT])
                block_q <= 1'b0;

            if (bite_evt)
                bite_q <= 1'b1;
            else if (wr_stat2 && bus_wdata[BITE_BIT])
                bite_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_RELOAD: bus_rdata[CNT_W-1:0]    = count;
            OFF_STAT1:  bus_rdata[WARN_BIT]     = warn_q;
            OFF_STAT2: begin
                        bus_rdata[BLOCK_BIT]    = block_q;
                        bus_rdata[BITE_BIT]     = bite_q;
            end
            OFF_CTRL:   bus_rdata               = ctrl_q;
            OFF_GUARD:  bus_rdata[0]            = guard_eff;
            OFF_START:  bus_rdata               = {start_hi_q, start_q};
            default:    bus_rdata               = '0;
        endcase
    end

    // R5
    start_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q >= CNT_W'(MIN_START));
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int TICK_DIV      = 120_000_000,
    parameter int CNT_W         = 10,
    parameter int START_DEFAULT = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              noreboot_strap,
    output logic              rst_req
);
    logic             halt, reload_wr, guard_eff, tick, expire;
    logic             warn_evt, bite_evt;
    logic [CNT_W-1:0] start_val, count;

    wdog_regs #(.CNT_W(CNT_W), .START_DEFAULT(START_DEFAULT)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .noreboot_strap(noreboot_strap), .count(count),
        .warn_evt(warn_evt), .bite_evt(bite_evt), .halt(halt),
        .reload_wr(reload_wr), .start_val(start_val), .guard_eff(guard_eff)
    );

    wdog_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(!halt), .restart(reload_wr), .tick(tick)
    );

    wdog_countdown #(.CNT_W(CNT_W), .START_DEFAULT(START_DEFAULT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(reload_wr), .tick(tick),
        .start_val(start_val), .count(count), .expire(expire)
    );

    wdog_stage_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .expire(expire), .rearm(reload_wr),
        .warn_evt(warn_evt), .bite_evt(bite_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rst_req <= 1'b0;
        else
            rst_req <= bite_evt && !guard_eff;
    end

    // R3
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(halt) && !$past(reload_wr)) |-> $stable(count));
    // R7
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R8
    req_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(guard_eff));
endmodule

// File: tb/test_wdog_two_stage.sv
`timescale 1ns/1ps
module test_wdog_two_stage;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        noreboot_strap = 1'b0;
    logic        rst_req;

    int vectors = 0;
    int errors  = 0;
    int pulses  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    wdog_two_stage #(.TICK_DIV(DIV)) i_wdog_two_stage (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .noreboot_strap(noreboot_strap), .rst_req(rst_req)
    );

    always @(negedge clk) if (rst_n && rst_req) pulses++;

    function automatic logic [15:0] exp_start(logic [15:0] old_v, logic [15:0] wr_v);
        if (wr_v[9:0] < 10'd4) return {wr_v[15:10], old_v[9:0]};
        return wr_v;
    endfunction

    function automatic int exp_count(int start, int n);
        return start - n / DIV;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // halt, program start value, reload, clear status; leaves block halted
    task automatic setup(logic [15:0] start);
        wr(5'h08, 16'h0800);
        wr(5'h12, start);
        wr(5'h00, 16'h1234);
        wr(5'h04, 16'h0008);
        wr(5'h06, 16'h0003);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [15:0] d, c1, shadow;
        int base;
        void'($urandom(32'h00C0FFEE));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(5'h08, d); check("R1 ctrl", d, 16'h0800);
        rd(5'h12, d); check("R1 start", d, 16'h0032);
        rd(5'h00, d); check("R1 count", d, 16'd50);
        rd(5'h0A, d); check("R1 guard", d, 16'h0001);
        rd(5'h04, d); check("R1 stat1", d, 16'h0000);
        rd(5'h06, d); check("R1 stat2", d, 16'h0000);
        check("R1 rst_req", {15'b0, rst_req}, 16'h0000);

        // R2 R6 R7 expiry sequence with guard clear
        setup(16'd5);
        wr(5'h0A, 16'h0000);
        rd(5'h0A, d); check("R8 guard cleared", d, 16'h0000);
        base = pulses;
        wr(5'h08, 16'h0000);
        idle(9);  rd(5'h00, d); check("R2 count", d, 16'(exp_count(5, 9)));
        idle(15); rd(5'h00, d); check("R6 reload after expiry", d, 16'd5);
        rd(5'h04, d); check("R6 warn bit", d, 16'h0008);
        check("R6 no request", 16'(pulses - base), 16'd0);
        rd(5'h06, d); check("R6 stat2 quiet", d, 16'h0000);
        idle(23); rd(5'h00, d); check("R2 count at zero", d, 16'd0);
        idle(3);  rd(5'h06, d); check("R7 bite bit", d, 16'h0002);
        check("R7 single pulse", 16'(pulses - base), 16'd1);

        // R3 halt freezes count, ctrl reads back
        wr(5'h08, 16'h0800);
        rd(5'h00, c1);
        idle(20);
        rd(5'h00, d); check("R3 frozen", d, c1);
        for (int i = 0; i < 8; i++) begin
            logic [15:0] v;
            v = 16'($urandom) | 16'h0800;
            wr(5'h08, v);
            rd(5'h08, d); check("R3 ctrl readback", d, v);
        end
        rd(5'h00, d); check("R3 still frozen", d, c1);

        // R9 write-one-to-clear
        wr(5'h06, 16'h0000); rd(5'h06, d); check("R9 write 0 keeps", d, 16'h0002);
        wr(5'h06, 16'h0002); rd(5'h06, d); check("R9 clear bite", d, 16'h0000);
        wr(5'h04, 16'h0000); rd(5'h04, d); check("R9 warn kept", d, 16'h0008);
        wr(5'h04, 16'h0008); rd(5'h04, d); check("R9 warn clear", d, 16'h0000);

        // R5 start-value legality, random with forced small fields
        rd(5'h12, shadow);
        for (int i = 0; i < 12; i++) begin
            logic [15:0] v;
            v = 16'($urandom);
            if (i % 3 == 0) v[9:0] = 10'($urandom_range(0, 3));
            wr(5'h12, v);
            shadow = exp_start(shadow, v);
            rd(5'h12, d); check("R5 start readback", d, shadow);
        end

        // R8 strap forces guard and blocks request
        setup(16'd5);
        noreboot_strap = 1'b1;
        wr(5'h0A, 16'h0000);
        rd(5'h0A, d); check("R8 strap forces guard", d, 16'h0001);
        base = pulses;
        wr(5'h08, 16'h0000);
        idle(50);
        rd(5'h06, d); check("R8 blocked bite", d, 16'h0003);
        check("R8 no request", 16'(pulses - base), 16'd0);
        noreboot_strap = 1'b0;
        rd(5'h0A, d); check("R8 stored flag", d, 16'h0000);

        // R10 and R4 reload between expiries
        setup(16'd5);
        base = pulses;
        wr(5'h08, 16'h0000);
        idle(26);
        rd(5'h04, d); check("R10 first warn", d, 16'h0008);
        wr(5'h04, 16'h0008);
        wr(5'h00, 16'h0000);
        idle(30);
        rd(5'h04, d); check("R10 warn again", d, 16'h0008);
        rd(5'h06, d); check("R10 no bite", d, 16'h0000);
        rd(5'h00, d); check("R4 count after reload", d, 16'd4);
        check("R10 no request", 16'(pulses - base), 16'd0);

        // R4 reload while halted waits for unhalt; R2 random countdowns
        for (int i = 0; i < 8; i++) begin
            int st, n;
            st = $urandom_range(4, 15);
            n  = $urandom_range(0, DIV * (st + 1) - 1);
            setup(16'(st));
            idle(7);
            rd(5'h00, d); check("R4 halted load", d, 16'(st));
            wr(5'h08, 16'h0000);
            idle(n);
            rd(5'h00, d); check("R2 random count", d, 16'(exp_count(st, n)));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule